// File: doc/BRIEF.md
# Period Timer with Selectable Hardware Reset

This block is an up-counter with a prescaler, a programmable period and one external condition input. The condition input is synchronized by a two-stage flop chain, and its active sense is set by a polarity bit. A two-bit field picks how the counter is reset by hardware. The choices are: no hardware reset (free wrap), a level on the condition input, a start event, or period match only. A reset event always takes priority over counting.

The counter advances once for every prescaler wrap while the run request is high. A single-cycle match pulse marks the counting step taken while the count equals the period. A sticky zero flag records every change of the count from a nonzero value to zero, and a write-one-to-clear input clears it. A defined collision rule covers a reset event that arrives while the count sits at the period value. If the event comes before the step, the counter and the prescaler clear at once and no pulse is issued. If the event lands on the step itself, the pulse is still issued.

Top module: `period_timer`

## Requirements
- R1: With `rst_mode`=0 there is no hardware reset: the count advances on every counting step up to 2^CNT_W-1, then wraps to 0, and the period value never clears it.
- R2: With `rst_mode`=3 the count clears on the counting step taken while count equals `period`. `match_pulse_o` is high for exactly that cycle, which is the only cycle in which it is high.
- R3: A counting step occurs once every `psc_val`+1 clocks while `run_req` is high. The count changes only on a counting step or on a reset event.
- R4: With `rst_mode`=1 the count is held at 0 and `run_o` is 0 while the synchronized condition is active. Active means `ers_i` low when `ers_pol`=0 and `ers_i` high when `ers_pol`=1.
- R5: With `rst_mode`=1, when the condition is inactive the count also clears at period match.
- R6: With `rst_mode`=2 the first clock of a run (the rising edge of `run_o`) clears the count and the prescaler. This adds one counting step before the first period match. Period match also clears the count.
- R7: With `rst_mode`=2 only the transition of the condition into its active level resets the counter. Holding the level does not stop counting.
- R8: `zif_o` sets when the count changes from nonzero to zero, for any reason, and stays set until `zif_clr` is high at a clock edge with no new set. A reset event while the count is already 0 leaves it clear.
- R9: A condition or start reset event in a cycle where count equals `period` but no counting step occurs clears both the count and the prescaler at the next edge, and no match pulse is issued.
- R10: A reset event in the cycle of the counting step at period match still lets `match_pulse_o` go high. The count returns to 0 at that edge and the prescaler continues from 0.
- R11: A synchronous `rst` gives count 0, `run_o` 0, `zif_o` 0 and `match_pulse_o` 0.
- R12: `ers_i` reaches the reset logic through a two-flop synchronizer. A change on `ers_i` takes effect on `run_o` two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| run_req | input | 1 | Run request; its rising edge (as seen on `run_o`) is the start event |
| ers_i | input | 1 | External condition input, asynchronous |
| ers_pol | input | 1 | 0: condition active low, 1: condition active high |
| psc_val | input | PSC_W | Prescaler divide value minus one |
| period | input | CNT_W | Period compare value |
| rst_mode | input | 2 | 0 none, 1 level, 2 start, 3 period match |
| zif_clr | input | 1 | Write-one-to-clear for the zero flag |
| count_o | output | CNT_W | Current count |
| run_o | output | 1 | Timer running (request and not held by level reset) |
| zif_o | output | 1 | Sticky zero flag |
| match_pulse_o | output | 1 | One-cycle pulse on the counting step at period match |

## Verification
The assertions assume that `rst_mode`, `ers_pol`, `psc_val` and `period` are static while the timer runs. They also assume that any level on `ers_i` is held for at least one full clock, so that the synchronizer samples it. The bench changes the configuration only while `rst` is asserted. It holds every condition level for many cycles, and it moves `ers_i` only one nanosecond after a rising edge, which keeps the synchronizer's timing fixed and predictable.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  typedef enum logic [1:0] {
    RST_NONE  = 2'd0,
    RST_LEVEL = 2'd1,
    RST_START = 2'd2,
    RST_MATCH = 2'd3
  } rst_mode_e;

  // True when the synchronized condition sits at its active sense
  function automatic logic cond_active(input logic lvl, input logic pol);
    return pol ? lvl : ~lvl;
  endfunction

  // Value the count takes on a counting step
  function automatic logic [15:0] count_step(input logic [15:0] cur,
                                             input logic match,
                                             input logic clr_on_match);
    if (match && clr_on_match) return '0;
    return cur + 16'd1;
  endfunction

endpackage

// File: rtl/ptm_ers_cond.sv
module ptm_ers_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ers_i,
  input  logic pol_i,
  output logic act_o,
  output logic edge_o,
  output logic hold_o
);
  import ptm_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   act_prev;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) sync_q[0] <= ers_i;
      end else begin : g_next
        always_ff @(posedge clk) sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) prev_q <= sync_q[SYNC_STAGES-1];

  assign act_o    = cond_active(sync_q[SYNC_STAGES-1], pol_i);
  assign act_prev = cond_active(prev_q, pol_i);
  assign edge_o   = act_o && !act_prev;
  assign hold_o   = act_o && act_prev;

  // R7: leading edge never lasts two cycles
  assert_edge_single_R7: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);

endmodule

// File: rtl/ptm_prescaler.sv
module ptm_prescaler #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_val,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q;

  assign tick_o = run_i && (psc_q == psc_val);

  always_ff @(posedge clk) begin
    if (rst || clr_i)  psc_q <= '0;
    else if (tick_o)   psc_q <= '0;
    else if (run_i)    psc_q <= psc_q + 1'b1;
  end

  // R3: divider stays put while no run request
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> $stable(psc_q));

endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             wrap_en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             to_zero_o
);
  import ptm_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [15:0]      step_val;

  assign match_o  = (cnt_q == period_i);
  assign step_val = count_step(16'(cnt_q), match_o, wrap_en_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = step_val[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign to_zero_o = (cnt_q != '0) && (cnt_d == '0) && !rst;

  // R3: count moves only on a step or a clear
  assert_count_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
  // R1: free wrap mode increments modulo full range
  assert_free_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_i && !wrap_en_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R2: step at match with clearing enabled lands on zero
  assert_match_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && match_o && wrap_en_i) |=> cnt_q == '0);

endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_req,
  input  logic             ers_i,
  input  logic             ers_pol,
  input  logic [PSC_W-1:0] psc_val,
  input  logic [CNT_W-1:0] period,
  input  logic [1:0]       rst_mode,
  input  logic             zif_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             zif_o,
  output logic             match_pulse_o
);
  import ptm_pkg::*;

  rst_mode_e mode;
  logic cond_act, cond_edge, cond_hold;
  logic lvl_active, lvl_hold;
  logic run_q, start_evt, start_rst, rst_evt;
  logic tick, match, to_zero;
  logic zif_q;

  assign mode = rst_mode_e'(rst_mode);

  ptm_ers_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .ers_i(ers_i), .pol_i(ers_pol),
    .act_o(cond_act), .edge_o(cond_edge), .hold_o(cond_hold)
  );

  // Level reset: held at zero, run forced low
  assign lvl_active = (mode == RST_LEVEL) && cond_act;
  assign lvl_hold   = (mode == RST_LEVEL) && cond_hold;
  assign run_o      = run_req && !lvl_active && !rst;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run_o;
  end

  assign start_evt = run_o && !run_q;
  assign start_rst = (mode == RST_START) && (start_evt || cond_edge);
  assign rst_evt   = lvl_active || start_rst;

  ptm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .clr_i(rst_evt), .run_i(run_req),
    .psc_val(psc_val), .tick_o(tick)
  );

  ptm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(rst_evt), .tick_i(tick),
    .wrap_en_i(mode != RST_NONE), .period_i(period),
    .cnt_o(count_o), .match_o(match), .to_zero_o(to_zero)
  );

  // Pulse survives a reset that coincides with the step; a held level blocks it
  assign match_pulse_o = tick && match && !lvl_hold && !rst;

  always_ff @(posedge clk) begin
    if (rst)          zif_q <= 1'b0;
    else if (to_zero) zif_q <= 1'b1;
    else if (zif_clr) zif_q <= 1'b0;
  end
  assign zif_o = zif_q;

  // R4: active level forces zero on the next edge
  assert_level_hold_R4: assert property (@(posedge clk) disable iff (rst)
    lvl_active |=> count_o == '0);
  // R2: pulse only while count equals period
  assert_pulse_at_match_R2: assert property (@(posedge clk) disable iff (rst)
    match_pulse_o |-> count_o == period);
  // R6: start event clears the counter
  assert_start_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == RST_START && start_evt) |=> count_o == '0);
  // R9: reset in the match window without a step clears the count
  assert_window_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rst_evt && match && !tick) |=> count_o == '0);
  // R8: flag is sticky without a clear
  assert_zif_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (zif_o && !zif_clr) |=> zif_o);
  // R8: an already-zero count cannot raise the flag
  assert_zif_from_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (count_o == '0 && !zif_o) |=> !zif_o);

endmodule

// File: tb/tb_period_timer.sv
module tb_period_timer;
  localparam int CNT_W = 8;
  localparam int PSC_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_req = 1'b0;
  logic ers_i = 1'b1;
  logic ers_pol = 1'b0;
  logic [PSC_W-1:0] psc_val = '0;
  logic [CNT_W-1:0] period = '0;
  logic [1:0] rst_mode = 2'd0;
  logic zif_clr = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic run_o, zif_o, match_pulse_o;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  period_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dut (
    .clk(clk), .rst(rst), .run_req(run_req), .ers_i(ers_i), .ers_pol(ers_pol),
    .psc_val(psc_val), .period(period), .rst_mode(rst_mode), .zif_clr(zif_clr),
    .count_o(count_o), .run_o(run_o), .zif_o(zif_o), .match_pulse_o(match_pulse_o)
  );

  always @(negedge clk) if (!rst && match_pulse_o) pulses++;

  // {mode[37:36], psc[35:32], period[31:24], edges[23:8], expected count[7:0]}
  localparam logic [37:0] VEC [0:8] = '{
    {2'd0, 4'd0, 8'd5, 16'd10,  8'd10},  // R1 free run
    {2'd3, 4'd0, 8'd5, 16'd10,  8'd4 },  // R2 match clear
    {2'd1, 4'd0, 8'd5, 16'd10,  8'd4 },  // R5 level mode match clear
    {2'd2, 4'd0, 8'd5, 16'd10,  8'd3 },  // R6 one extra step
    {2'd3, 4'd2, 8'd3, 16'd14,  8'd0 },  // R3 divide by 3
    {2'd0, 4'd1, 8'd3, 16'd14,  8'd7 },  // R3 divide by 2
    {2'd2, 4'd1, 8'd4, 16'd12,  8'd0 },  // R6 with prescaler
    {2'd0, 4'd0, 8'd3, 16'd260, 8'd4 },  // R1 full-range wrap
    {2'd3, 4'd3, 8'd2, 16'd21,  8'd2 }   // R3 divide by 4
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic restart(input logic [1:0] m, input logic pol, input logic e,
                         input logic [PSC_W-1:0] p, input logic [CNT_W-1:0] per);
    steps(1);
    rst = 1'b1; run_req = 1'b0; zif_clr = 1'b0;
    rst_mode = m; ers_pol = pol; ers_i = e; psc_val = p; period = per;
    steps(5);
    rst = 1'b0; run_req = 1'b1;
    pulses = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    steps(5);
    check("R11 count", count_o, 0);
    check("R11 run", run_o, 0);
    check("R11 zif", zif_o, 0);
    check("R11 pulse", match_pulse_o, 0);

    // Vector table
    for (int i = 0; i < 9; i++) begin
      restart(VEC[i][37:36], 1'b0, 1'b1, VEC[i][35:32], VEC[i][31:24]);
      steps(int'(VEC[i][23:8]));
      check($sformatf("R1/R2/R3/R5/R6 vector %0d", i), count_o, int'(VEC[i][7:0]));
    end

    // R2: pulse timing and width, R8 set and clear
    restart(2'd3, 1'b0, 1'b1, 4'd0, 8'd3);
    steps(3);
    check("R2 pulse at match", match_pulse_o, 1);
    check("R8 zif before wrap", zif_o, 0);
    steps(1);
    check("R2 pulse one cycle", match_pulse_o, 0);
    check("R2 count cleared", count_o, 0);
    check("R8 zif set on wrap", zif_o, 1);
    zif_clr = 1'b1;
    steps(1);
    zif_clr = 1'b0;
    check("R8 zif cleared", zif_o, 0);

    // R4 / R12: active-low level reset
    restart(2'd1, 1'b0, 1'b1, 4'd0, 8'd20);
    steps(3);
    check("R4 counting", count_o, 3);
    ers_i = 1'b0;
    steps(1);
    check("R12 run still high after one edge", run_o, 1);
    steps(1);
    check("R12 run low after two edges", run_o, 0);
    steps(1);
    check("R4 count held zero", count_o, 0);
    check("R8 zif on level reset", zif_o, 1);
    steps(4);
    check("R4 still held", count_o, 0);
    check("R4 run forced low", run_o, 0);
    ers_i = 1'b1;
    steps(2);
    check("R4 run back", run_o, 1);
    steps(1);
    check("R4 counting resumed", count_o, 1);

    // R4: inverted polarity
    restart(2'd1, 1'b1, 1'b0, 4'd0, 8'd20);
    steps(3);
    check("R4 pol1 counting", count_o, 3);
    ers_i = 1'b1;
    steps(2);
    check("R4 pol1 run low", run_o, 0);
    steps(1);
    check("R4 pol1 held", count_o, 0);

    // R8: reset while already zero leaves the flag clear
    restart(2'd1, 1'b0, 1'b0, 4'd0, 8'd5);
    steps(6);
    check("R8 no zif from zero", zif_o, 0);
    check("R4 held from start", count_o, 0);

    // R9 / R7: edge event inside match window, prescaler 3, period 2
    restart(2'd2, 1'b1, 1'b0, 4'd3, 8'd2);
    steps(8);
    ers_i = 1'b1;
    steps(1);
    check("R9 at match value", count_o, 2);
    steps(2);
    check("R9 cleared early", count_o, 0);
    steps(3);
    check("R9 prescaler restarted", count_o, 0);
    check("R9 no pulse", pulses, 0);
    steps(1);
    check("R9 first step after clear", count_o, 1);
    steps(4);
    check("R7 level held does not stop", count_o, 2);

    // R10: event lands on the step at match
    restart(2'd2, 1'b1, 1'b0, 4'd3, 8'd2);
    steps(10);
    ers_i = 1'b1;
    steps(2);
    check("R10 pulse kept", match_pulse_o, 1);
    steps(1);
    check("R10 count wrapped", count_o, 0);
    steps(3);
    check("R10 natural prescaler", count_o, 0);
    steps(1);
    check("R10 next step", count_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule